// File: doc/BRIEF.md
# Inverter Fault Latch and Drive Gate

This block sits between a PWM generator and the gate drivers of a three-phase inverter bridge. It passes the six switch commands through while the bridge is healthy, and blocks all of them as soon as an undervoltage, overcurrent or overtemperature flag is raised. A single fault latch records the trip, and the drives stay blocked until the latch is cleared.

Clearing is deliberate. The clear request is synchronised into the clock domain and must stay high for a minimum time, counted in clock cycles, before it has any effect. A fault that is still present when the request qualifies keeps the latch set. The latch comes out of system reset already set. Power-up and power-down therefore hold the bridge off through the undervoltage flag until software issues a valid clear.

Top module: `inv_fault_gate`

## Requirements
- R1: A high level on any of `uv_flag`, `oc_flag` or `ot_flag` sampled at a rising clock edge sets the latch, and `fault_led` is high after that edge.
- R2: While the latch is set or any fault flag is high, `pwm_out` is all zeros. Otherwise `pwm_out` equals `pwm_in` in the same cycle, with no register in the path.
- R3: After system reset (`rst_n` low), the latch is set, `fault_led` is 1, `pwm_out` is 0 and all three status outputs are 0.
- R4: `oc_stat` (or `ot_stat`) is high after the first edge at which `oc_flag` (or `ot_flag`) is sampled high. It stays high after the flag drops, and falls only at the edge where the latch clears.
- R5: `uv_stat` repeats `uv_flag` one cycle later. The undervoltage flag going low does not clear the latch.
- R6: A clear request that the synchroniser sees high for at least MIN_CYC consecutive cycles clears the latch. MIN_CYC is the ceiling of CLK_KHZ*RST_MIN_NS/1e6, which is 50 at the defaults (50 MHz, 1000 ns). The latch clears two cycles after the MIN_CYC-th cycle of the held request. A request held for MIN_CYC-1 cycles is ignored.
- R7: If any fault flag is high in the cycle where a clear would take effect, the fault wins. The latch and the status of that fault stay set.
- R8: `fault_led` shows the latch state. It goes low only at a qualified clear with no fault active, and `pwm_out` follows `pwm_in` from the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| pwm_in | input | NUM_SW | Switch commands from the PWM generator |
| uv_flag | input | 1 | Local supply undervoltage |
| oc_flag | input | 1 | Overcurrent trip |
| ot_flag | input | 1 | Overtemperature trip |
| clr_req | input | 1 | Asynchronous latch clear request, active high |
| pwm_out | output | NUM_SW | Gated switch commands |
| uv_stat | output | 1 | Undervoltage status, registered copy of the flag |
| oc_stat | output | 1 | Sticky overcurrent status |
| ot_stat | output | 1 | Sticky overtemperature status |
| fault_led | output | 1 | Latch set indicator |

## Verification
A fault flag changes `pwm_out` in the same cycle. It changes `fault_led` and the status outputs after one edge. A clear request held for N cycles reaches the latch through two synchroniser flops and a width counter, so the latch falls at the (N+2)-th edge after the request is first sampled. The bench drives every input on the falling edge. It checks combinational results after a short settle delay in the same half cycle. It checks registered results on the falling edge after the edge where they are due, and it checks the clear only a few cycles after the computed edge. Pulse widths of MIN_CYC-1 and MIN_CYC cover the qualification boundary.

// File: rtl/inv_fault_gate.sv
module inv_fault_gate #(
  parameter int NUM_SW     = 6,
  parameter int CLK_KHZ    = 50000,
  parameter int RST_MIN_NS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SW-1:0] pwm_in,
  input  logic              uv_flag,
  input  logic              oc_flag,
  input  logic              ot_flag,
  input  logic              clr_req,
  output logic [NUM_SW-1:0] pwm_out,
  output logic              uv_stat,
  output logic              oc_stat,
  output logic              ot_stat,
  output logic              fault_led
);

  localparam int RAW_CYC = (CLK_KHZ * RST_MIN_NS + 999_999) / 1_000_000;
  localparam int MIN_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;
  localparam int CW      = $clog2(MIN_CYC + 1);

  logic          clr_s1, clr_s2;
  logic [CW-1:0] hold_cnt;
  logic          tripped;

  wire any_fault = uv_flag | oc_flag | ot_flag;
  wire clr_ok    = clr_s2 && (int'(hold_cnt) >= MIN_CYC - 1);
  wire do_clear  = clr_ok && !any_fault;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clr_s1 <= 1'b0;
      clr_s2 <= 1'b0;
    end else begin
      clr_s1 <= clr_req;
      clr_s2 <= clr_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       hold_cnt <= '0;
    else if (!clr_s2)                 hold_cnt <= '0;
    else if (int'(hold_cnt) < MIN_CYC) hold_cnt <= hold_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tripped <= 1'b1;
      oc_stat <= 1'b0;
      ot_stat <= 1'b0;
      uv_stat <= 1'b0;
    end else begin
      uv_stat <= uv_flag;
      if (any_fault)     tripped <= 1'b1;
      else if (clr_ok)   tripped <= 1'b0;
      if (oc_flag)       oc_stat <= 1'b1;
      else if (do_clear) oc_stat <= 1'b0;
      if (ot_flag)       ot_stat <= 1'b1;
      else if (do_clear) ot_stat <= 1'b0;
    end

  assign fault_led = tripped;
  assign pwm_out   = (tripped || any_fault) ? '0 : pwm_in;

  p_fault_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag || oc_flag || ot_flag) |=> fault_led);

  p_drive_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_led |-> (pwm_out == '0));

  p_oc_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_stat && fault_led) |=> (oc_stat || !fault_led));

  p_uv_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (uv_stat == $past(uv_flag)));

  p_clear_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_led) |-> $past(clr_s2));

  p_fault_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_led) |-> !$past(uv_flag || oc_flag || ot_flag));

  p_clear_drops_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_led) |-> (!oc_stat && !ot_stat));

endmodule

// File: tb/inv_fault_gate_test.sv
module inv_fault_gate_test;
  localparam int MIN_CYC = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] pwm_in = 6'h15;
  logic       uv_flag = 1'b0, oc_flag = 1'b0, ot_flag = 1'b0, clr_req = 1'b0;
  logic [5:0] pwm_out;
  logic       uv_stat, oc_stat, ot_stat, fault_led;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  inv_fault_gate uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .uv_flag(uv_flag),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .clr_req(clr_req),
    .pwm_out(pwm_out), .uv_stat(uv_stat), .oc_stat(oc_stat),
    .ot_stat(ot_stat), .fault_led(fault_led));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear(input int n);
    @(negedge clk) clr_req = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk) clr_req = 1'b0;
    cycles(4);
  endtask

  task automatic t_reset;
    check(fault_led, 1, "R3 led after reset");
    check(pwm_out, 0, "R3 pwm after reset");
    check({uv_stat, oc_stat, ot_stat}, 0, "R3 status after reset");
  endtask

  task automatic t_short_then_valid;
    pulse_clear(MIN_CYC - 1);
    check(fault_led, 1, "R6 short request ignored");
    check(pwm_out, 0, "R6 pwm still blocked");
    pulse_clear(MIN_CYC);
    check(fault_led, 0, "R6 full-width request clears");
    check(pwm_out, 6'h15, "R8 pwm passes after clear");
  endtask

  task automatic t_clear_timing;
    @(negedge clk) oc_flag = 1'b1;
    @(negedge clk) oc_flag = 1'b0;
    clr_req = 1'b1;
    repeat (MIN_CYC + 1) @(posedge clk);
    #1 check(fault_led, 1, "R6 not cleared one edge early");
    @(posedge clk) #1 check(fault_led, 0, "R6 clears at edge MIN_CYC+2");
    @(negedge clk) clr_req = 1'b0;
    check(oc_stat, 0, "R4 oc status dropped on clear");
    cycles(2);
  endtask

  task automatic t_pass;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) pwm_in = 6'(6'h09 << i) ^ 6'h2a;
      #1 check(pwm_out, 6'(6'h09 << i) ^ 6'h2a, "R2 pass-through pattern");
    end
  endtask

  task automatic t_fault(input int src);
    @(negedge clk) pwm_in = 6'h3f;
    case (src) 0: uv_flag = 1'b1; 1: oc_flag = 1'b1; default: ot_flag = 1'b1; endcase
    #1 check(pwm_out, 0, "R2 same-cycle block");
    @(negedge clk);
    check(fault_led, 1, "R1 latch set by fault");
    if (src == 1) check(oc_stat, 1, "R4 oc status high");
    if (src == 2) check(ot_stat, 1, "R4 ot status high");
    if (src == 0) check(uv_stat, 1, "R5 uv status high");
    uv_flag = 1'b0; oc_flag = 1'b0; ot_flag = 1'b0;
    cycles(2);
    check(fault_led, 1, "R1 latch holds after flag drops");
    check(pwm_out, 0, "R2 blocked after flag drops");
    if (src == 1) check(oc_stat, 1, "R4 oc status sticky");
    if (src == 2) check(ot_stat, 1, "R4 ot status sticky");
    if (src == 0) check(uv_stat, 0, "R5 uv status follows flag low");
    pulse_clear(MIN_CYC);
    check(fault_led, 0, "R8 led off after clear");
    check({oc_stat, ot_stat}, 0, "R4 statuses cleared");
    check(pwm_out, 6'h3f, "R8 drive restored");
  endtask

  task automatic t_fault_wins;
    @(negedge clk) ot_flag = 1'b1;
    pulse_clear(MIN_CYC + 10);
    check(fault_led, 1, "R7 fault beats clear");
    check(ot_stat, 1, "R7 ot status kept");
    @(negedge clk) ot_flag = 1'b0;
    cycles(2);
    check(fault_led, 1, "R7 still set after fault drops");
    pulse_clear(MIN_CYC);
    check(fault_led, 0, "R7 clear after fault gone");
  endtask

  initial begin
    cycles(3);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_short_then_valid();
    t_pass();
    t_fault(0);
    t_fault(1);
    t_fault(2);
    t_clear_timing();
    t_fault_wins();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule